// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock Unit

This block sits beside the decode and execute stages of an in-order five-stage integer pipeline. Stages are fetch, decode, execute, memory and write-back. Every cycle it receives the instruction word currently in decode and keeps its own shadow copies of the decoded register fields for the three stages below decode. It compares the source registers of the instruction in execute with the destinations waiting in the memory and write-back stages. From that comparison it drives the bypass mux selects for both ALU operands and for store data.

It also finds the one case that bypass cannot cover: an instruction in decode that needs, as an ALU source, a register still being loaded by the instruction in execute. In that case it raises a stall for exactly one cycle. The fetch address and the decode latch hold, and a bubble enters execute. A store whose data register comes from the load just ahead of it is not stalled. Instead its data is patched late, in the memory stage, from the loaded value.

Top module: `hazard_bypass_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no valid instruction presented, `stall_o` and `st_late_o` are 0 and all three select outputs are 00.
- R2: Decoding uses opcode bits 31:26. The first source is bits 25:21 and the second source is bits 20:16. Opcode 0 is register form: it reads both sources and writes bits 15:11. Opcodes 8 to 15 are immediate form: they read bits 25:21 and write bits 20:16. Opcode 0x23 is a load: it reads bits 25:21 as base and writes bits 20:16. Opcode 0x2B is a store: it reads bits 25:21 as base and bits 20:16 as data. Opcodes 4 and 5 are compare-branches that read both sources. Any other opcode reads and writes nothing.
- R3: Each select uses the code 00 for the register file, 01 for the write-back stage and 10 for the memory stage. The code 11 never appears.
- R4: An ALU source of the instruction in execute that equals the destination of the instruction in the memory stage gets code 10 on `fwd_a_o` (first source) or `fwd_b_o` (second source).
- R5: A source that matches only the destination in the write-back stage gets code 01.
- R6: When both stages write the source register, the memory stage wins (10).
- R7: Register 0 is never a bypass source and never causes a stall, even when an instruction names it as destination.
- R8: An instruction in decode that reads, as an ALU or base source, the destination of a load in execute raises `stall_o` for exactly one cycle. The same instruction is then accepted and a bubble goes down the pipe.
- R9: After such a stall the dependent instruction reaches execute with the load in write-back, and its select is 01. A load in the memory stage is never selected as 10 for any operand.
- R10: `fwd_sd_o` selects the data of a store in execute. It uses the memory stage (10) only when that instruction is not a load, otherwise the write-back stage (01), otherwise 00.
- R11: A store whose data register is the destination of the immediately preceding load causes no stall. `st_late_o` is 1 while that store is in the memory stage and the load is in write-back.
- R12: The destination field of immediate and load forms is not compared as a source. The data field of a store never drives `fwd_b_o`, and an instruction with no register reads yields 00 selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | The decode latch holds a real instruction |
| id_instr | input | 32 | Instruction word in decode |
| stall_o | output | 1 | Hold fetch address and decode latch, insert bubble into execute |
| fwd_a_o | output | 2 | Select for ALU first operand |
| fwd_b_o | output | 2 | Select for ALU second operand |
| fwd_sd_o | output | 2 | Select for store data in execute |
| st_late_o | output | 1 | Replace store data in memory stage with loaded value |

## Verification
The assertions check several properties on every cycle. No select ever takes the code 11, and a stall never lasts two cycles. The cycle after a stall carries only 00 selects. A load sitting in the memory stage is never picked as a bypass source, and a 10 select always points at a real, non-zero destination. The late store patch is only ever raised with a load in write-back. Priority between the two stages, the exact stall trigger for each instruction form, and register 0 have to be shown by the bench. The same is true of the store path around a load and the field positions of each form. The bench shows these through directed sequences and a long random stream over a small register set, compared each cycle with its reference model.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int OP_W    = 6;
  localparam int OP_LSB  = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int SEL_W   = 2;

  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'h05;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

  // fully decoded instruction (decode and execute stages)
  typedef struct packed {
    logic             uses_rs;
    logic             uses_rt_alu;
    logic             uses_rt_sd;
    logic             is_load;
    logic             is_store;
    logic             wr_en;
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] wd;
  } hz_dec_t;

  // what the memory stage keeps
  typedef struct packed {
    logic             wr_en;
    logic             is_load;
    logic             is_store;
    logic [REG_W-1:0] wd;
    logic [REG_W-1:0] rt;
  } hz_mem_t;

  // what the write-back stage keeps
  typedef struct packed {
    logic             wr_en;
    logic             is_load;
    logic [REG_W-1:0] wd;
  } hz_wb_t;
endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_pkg::*;
(
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output hz_dec_t            dec
);
  logic [OP_W-1:0]  opc;
  logic [REG_W-1:0] f_rs, f_rt, f_rd;

  assign opc  = instr[OP_LSB +: OP_W];
  assign f_rs = instr[RS_LSB +: REG_W];
  assign f_rt = instr[RT_LSB +: REG_W];
  assign f_rd = instr[RD_LSB +: REG_W];

  always_comb begin
    dec    = '0;
    dec.rs = f_rs;
    dec.rt = f_rt;
    if (valid) begin
      if (opc == OPC_REG) begin
        dec.uses_rs     = 1'b1;
        dec.uses_rt_alu = 1'b1;
        dec.wr_en       = 1'b1;
        dec.wd          = f_rd;
      end else if (opc[OP_W-1:3] == 3'b001) begin
        dec.uses_rs = 1'b1;
        dec.wr_en   = 1'b1;
        dec.wd      = f_rt;
      end else if (opc == OPC_LOAD) begin
        dec.uses_rs = 1'b1;
        dec.is_load = 1'b1;
        dec.wr_en   = 1'b1;
        dec.wd      = f_rt;
      end else if (opc == OPC_STORE) begin
        dec.uses_rs    = 1'b1;
        dec.uses_rt_sd = 1'b1;
        dec.is_store   = 1'b1;
      end else if (opc == OPC_BEQ || opc == OPC_BNE) begin
        dec.uses_rs     = 1'b1;
        dec.uses_rt_alu = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hz_pipe_track.sv
module hz_pipe_track
  import hz_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stall,
  input  hz_dec_t id_dec,
  output hz_dec_t idex_q,
  output hz_mem_t exm_q,
  output hz_wb_t  mwb_q
);
  hz_dec_t idex_d;
  hz_mem_t exm_d;
  hz_wb_t  mwb_d;

  // next-state: a stall turns the execute entry into a bubble
  always_comb begin
    idex_d         = stall ? '0 : id_dec;
    exm_d.wr_en    = idex_q.wr_en;
    exm_d.is_load  = idex_q.is_load;
    exm_d.is_store = idex_q.is_store;
    exm_d.wd       = idex_q.wd;
    exm_d.rt       = idex_q.rt;
    mwb_d.wr_en    = exm_q.wr_en;
    mwb_d.is_load  = exm_q.is_load;
    mwb_d.wd       = exm_q.wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_q <= '0;
      exm_q  <= '0;
      mwb_q  <= '0;
    end else begin
      idex_q <= idex_d;
      exm_q  <= exm_d;
      mwb_q  <= mwb_d;
    end
  end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter bit SKIP_MEM_LOAD = 1'b0
) (
  input  logic             use_src,
  input  logic [REG_W-1:0] src,
  input  logic             exm_wr,
  input  logic             exm_ld,
  input  logic [REG_W-1:0] exm_wd,
  input  logic             mwb_wr,
  input  logic [REG_W-1:0] mwb_wd,
  output logic [SEL_W-1:0] sel
);
  logic live, hit_mem, hit_wb;

  assign live    = use_src && (src != '0);
  assign hit_mem = live && exm_wr && (exm_wd == src) && !(SKIP_MEM_LOAD && exm_ld);
  assign hit_wb  = live && mwb_wr && (mwb_wd == src);

  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse
  import hz_pkg::*;
(
  input  hz_dec_t id_dec,
  input  hz_dec_t idex_q,
  output logic    stall
);
  logic ld_live, hit_rs, hit_rt;

  assign ld_live = idex_q.is_load && (idex_q.wd != '0);
  assign hit_rs  = id_dec.uses_rs && (id_dec.rs == idex_q.wd);
  assign hit_rt  = id_dec.uses_rt_alu && (id_dec.rt == idex_q.wd);
  assign stall   = ld_live && (hit_rs || hit_rt);
endmodule

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit
  import hz_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id_valid,
  input  logic [INSTR_W-1:0] id_instr,
  output logic               stall_o,
  output logic [SEL_W-1:0]   fwd_a_o,
  output logic [SEL_W-1:0]   fwd_b_o,
  output logic [SEL_W-1:0]   fwd_sd_o,
  output logic               st_late_o
);
  localparam int N_PICK = 3;

  hz_dec_t id_dec, idex_q;
  hz_mem_t exm_q;
  hz_wb_t  mwb_q;
  logic    stall;

  logic             pick_use [N_PICK];
  logic [REG_W-1:0] pick_src [N_PICK];
  logic [SEL_W-1:0] pick_sel [N_PICK];

  hz_decode u_dec (.valid(id_valid), .instr(id_instr), .dec(id_dec));

  hz_loaduse u_lu (.id_dec(id_dec), .idex_q(idex_q), .stall(stall));

  hz_pipe_track u_trk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .id_dec(id_dec),
    .idex_q(idex_q), .exm_q(exm_q), .mwb_q(mwb_q)
  );

  assign pick_use[0] = idex_q.uses_rs;
  assign pick_src[0] = idex_q.rs;
  assign pick_use[1] = idex_q.uses_rt_alu;
  assign pick_src[1] = idex_q.rt;
  assign pick_use[2] = idex_q.uses_rt_sd;
  assign pick_src[2] = idex_q.rt;

  // pick 2 is store data: a load in the memory stage is patched later instead
  for (genvar g = 0; g < N_PICK; g++) begin : g_pick
    hz_fwd_pick #(.SKIP_MEM_LOAD(g == 2)) u_pick (
      .use_src(pick_use[g]), .src(pick_src[g]),
      .exm_wr(exm_q.wr_en), .exm_ld(exm_q.is_load), .exm_wd(exm_q.wd),
      .mwb_wr(mwb_q.wr_en), .mwb_wd(mwb_q.wd),
      .sel(pick_sel[g])
    );
  end

  assign stall_o   = stall;
  assign fwd_a_o   = pick_sel[0];
  assign fwd_b_o   = pick_sel[1];
  assign fwd_sd_o  = pick_sel[2];
  assign st_late_o = exm_q.is_store && mwb_q.is_load && (mwb_q.wd != '0) &&
                     (mwb_q.wd == exm_q.rt);
endmodule

// File: rtl/hz_checker.sv
module hz_checker
  import hz_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stall_o,
  input logic [SEL_W-1:0] fwd_a_o,
  input logic [SEL_W-1:0] fwd_b_o,
  input logic [SEL_W-1:0] fwd_sd_o,
  input logic             st_late_o,
  input logic             exm_wr,
  input logic             exm_ld,
  input logic [REG_W-1:0] exm_wd,
  input logic             mwb_ld
);
  logic any_mem;
  assign any_mem = (fwd_a_o == SEL_MEM) || (fwd_b_o == SEL_MEM) || (fwd_sd_o == SEL_MEM);

  p_sel_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_o != 2'b11) && (fwd_b_o != 2'b11) && (fwd_sd_o != 2'b11));

  p_single_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !stall_o);

  p_bubble_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> (fwd_a_o == SEL_RF) && (fwd_b_o == SEL_RF) && (fwd_sd_o == SEL_RF));

  p_load_not_bypassed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exm_ld |-> !any_mem);

  p_r0_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_mem |-> exm_wr && (exm_wd != '0));

  p_late_needs_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_late_o |-> mwb_ld);
endmodule

bind hazard_bypass_unit hz_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stall_o(stall_o),
  .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o), .fwd_sd_o(fwd_sd_o), .st_late_o(st_late_o),
  .exm_wr(exm_q.wr_en), .exm_ld(exm_q.is_load), .exm_wd(exm_q.wd),
  .mwb_ld(mwb_q.is_load)
);

// File: tb/tb_hazard_bypass_unit.sv
module tb_hazard_bypass_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0;
  logic [31:0] id_instr = '0;
  logic        stall_o, st_late_o;
  logic [1:0]  fwd_a_o, fwd_b_o, fwd_sd_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  hazard_bypass_unit dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_instr(id_instr),
    .stall_o(stall_o), .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o),
    .fwd_sd_o(fwd_sd_o), .st_late_o(st_late_o)
  );

  // reference pipe: index 0 execute, 1 memory, 2 write-back; -1 means none
  int m_a[3], m_b[3], m_d[3], m_dst[3];
  bit m_ld[3], m_st[3];
  bit [31:0] prog[$];

  function automatic bit [31:0] i_reg(int rd, int rs, int rt);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'h20};
  endfunction
  function automatic bit [31:0] i_imm(int rt, int rs);
    return {6'h08, rs[4:0], rt[4:0], 16'h0005};
  endfunction
  function automatic bit [31:0] i_ld(int rt, int base);
    return {6'h23, base[4:0], rt[4:0], 16'h0000};
  endfunction
  function automatic bit [31:0] i_st(int rt, int base);
    return {6'h2B, base[4:0], rt[4:0], 16'h000C};
  endfunction
  function automatic bit [31:0] i_br(int rs, int rt);
    return {6'h04, rs[4:0], rt[4:0], 16'h0010};
  endfunction
  function automatic bit [31:0] i_jmp();
    return {6'h02, 26'h40};
  endfunction

  // decode per R2, written from the field table
  task automatic bdec(input bit v, input bit [31:0] w, output int a, output int b,
                      output int d, output int dst, output bit ld, output bit st);
    int op = int'(w[31:26]);
    int f1 = int'(w[25:21]);
    int f2 = int'(w[20:16]);
    int f3 = int'(w[15:11]);
    a = -1; b = -1; d = -1; dst = -1; ld = 0; st = 0;
    if (!v) return;
    if (op == 0) begin a = f1; b = f2; dst = f3; end
    else if (op >= 8 && op <= 15) begin a = f1; dst = f2; end
    else if (op == 'h23) begin a = f1; dst = f2; ld = 1; end
    else if (op == 'h2B) begin a = f1; d = f2; st = 1; end
    else if (op == 4 || op == 5) begin a = f1; b = f2; end
  endtask

  function automatic int pick(int src, bit skip_ld);
    if (src <= 0) return 0;
    if (m_dst[1] == src && !(skip_ld && m_ld[1])) return 2;
    if (m_dst[2] == src) return 1;
    return 0;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 3; i++) begin
      m_a[i] = -1; m_b[i] = -1; m_d[i] = -1; m_dst[i] = -1; m_ld[i] = 0; m_st[i] = 0;
    end
  endtask

  task automatic check(string tag, int ea, int eb, int ed, bit es, bit el);
    n_cmp++;
    if (fwd_a_o != ea[1:0] || fwd_b_o != eb[1:0] || fwd_sd_o != ed[1:0] ||
        stall_o != es || st_late_o != el || fwd_a_o === 2'b11) begin
      n_bad++;
      $display("FAIL %s: got a=%0d b=%0d sd=%0d stall=%0b late=%0b exp a=%0d b=%0d sd=%0d stall=%0b late=%0b",
               tag, fwd_a_o, fwd_b_o, fwd_sd_o, stall_o, st_late_o, ea, eb, ed, es, el);
    end
  endtask

  // run the program in prog through the model and the design, plus drain cycles
  task automatic run(string tag);
    int ptr = 0;
    int drain = 0;
    while (drain < 4) begin
      int ia, ib, id, idst, ea, eb, ed;
      bit ild, ist, v, es, el;
      @(posedge clk);
      #1;
      v = (ptr < prog.size());
      id_valid = v;
      id_instr = v ? prog[ptr] : 32'h0;
      @(negedge clk);
      bdec(v, id_instr, ia, ib, id, idst, ild, ist);
      ea = pick(m_a[0], 0);
      eb = pick(m_b[0], 0);
      ed = pick(m_d[0], 1);
      es = m_ld[0] && m_dst[0] > 0 && (ia == m_dst[0] || ib == m_dst[0]);
      el = m_st[1] && m_ld[2] && m_dst[2] > 0 && m_dst[2] == m_d[1];
      check(tag, ea, eb, ed, es, el);
      for (int i = 2; i > 0; i--) begin
        m_a[i] = m_a[i-1]; m_b[i] = m_b[i-1]; m_d[i] = m_d[i-1];
        m_dst[i] = m_dst[i-1]; m_ld[i] = m_ld[i-1]; m_st[i] = m_st[i-1];
      end
      if (es) begin
        m_a[0] = -1; m_b[0] = -1; m_d[0] = -1; m_dst[0] = -1; m_ld[0] = 0; m_st[0] = 0;
      end else begin
        m_a[0] = ia; m_b[0] = ib; m_d[0] = id; m_dst[0] = idst; m_ld[0] = ild; m_st[0] = ist;
        if (v) ptr++;
      end
      if (!v) drain++;
    end
    prog.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    clear_model();
    repeat (4) @(negedge clk);
    check("R1 in reset", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 0, 0, 0, 0, 0);

    // R4 R5 R2: one and two ahead
    prog = '{i_reg(1,2,3), i_reg(4,1,3), i_reg(6,7,1), i_reg(8,1,9)};
    run("R4 R5 R2 basic bypass");

    // R6: both stages write r5
    prog = '{i_imm(5,0), i_imm(5,5), i_reg(6,5,5)};
    run("R6 priority");

    // R7: r0 as destination
    prog = '{i_reg(0,1,2), i_reg(3,0,0), i_ld(0,2), i_reg(1,0,0), i_br(0,0)};
    run("R7 register zero");

    // R8 R9: load then dependent use
    prog = '{i_ld(1,2), i_reg(4,1,6), i_reg(6,1,7), i_reg(8,1,9)};
    run("R8 R9 load-use");
    prog = '{i_ld(3,2), i_reg(4,6,3), i_ld(5,2), i_br(5,5), i_ld(7,1), i_ld(8,7)};
    run("R8 R9 second source and base");

    // R10 R11: store data paths
    prog = '{i_ld(4,1), i_st(4,1), i_imm(4,2), i_st(4,1), i_reg(9,1,1), i_reg(2,3,3), i_st(9,2)};
    run("R10 R11 store data");
    prog = '{i_ld(2,1), i_st(3,2), i_imm(4,4), i_ld(4,1), i_st(4,1)};
    run("R10 R11 store base and older writer");

    // R12: fields that must not be compared
    prog = '{i_reg(7,8,9), i_imm(7,1), i_reg(9,1,1), i_st(9,0), i_jmp(), i_ld(9,3), i_jmp()};
    run("R12 unused fields");

    // R3 R4 R5 R6 R8 R10 R11: random stream over r0..r3
    for (int k = 0; k < 2000; k++) begin
      int kind = $urandom_range(0, 5);
      int r1 = $urandom_range(0, 3);
      int r2 = $urandom_range(0, 3);
      int r3 = $urandom_range(0, 3);
      case (kind)
        0: prog.push_back(i_reg(r1, r2, r3));
        1: prog.push_back(i_imm(r1, r2));
        2: prog.push_back(i_ld(r1, r2));
        3: prog.push_back(i_st(r1, r2));
        4: prog.push_back(i_br(r1, r2));
        default: prog.push_back(i_jmp());
      endcase
    end
    run("R3 R4 R5 R6 R8 R10 R11 random");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule